// File: doc/BRIEF.md
# Bus Parity Generator with System-Error Interrupt

This block produces the even parity bit that travels with a 32-bit multiplexed address/data bus and its four command/byte-enable lines, for a bridge that can be either the initiator or the responder of a bus cycle. Each clock the surrounding logic presents the values it would place on the AD and C/BE lines. It also gives a phase indicator (address or data) and the current role and transfer direction. The block decides whether this agent owns the AD lines in that phase and reports this on `ad_drive`. One clock later it presents the parity of those 36 bits on `par_out`, together with an enable `par_drive` for the pad.

The block never checks parity on received data. A separate path watches the shared, active-low system-error line that other agents may pull. It synchronises that line and turns each sampled high-to-low transition into a sticky interrupt request for the non-maskable interrupt logic, but only while the enable input is set. Software removes the request with a clear pulse.

Top module: `pcipar_top`

## Requirements
- R1: `par_out` equals the XOR of all 36 bits of `ad_val` and `cbe_val` presented in the previous clock, so the 37 bits together hold an even number of ones.
- R2: All 36 bits are counted whatever their values, including when every `cbe_val` bit is 1 (no byte lane enabled).
- R3: `par_drive` equals the value `ad_drive` had one clock earlier, so the parity pad stays enabled for exactly one clock after AD ownership ends.
- R4: With `role_mst`=1 (master) and `phase_vld`=1, `ad_drive` is 1 in every address phase (`phase_addr`=1) for reads and writes, and in data phases (`phase_addr`=0) only when `cyc_wr`=1 (write).
- R5: With `role_mst`=0 (target) and `phase_vld`=1, `ad_drive` is 1 only in data phases of reads (`phase_addr`=0, `cyc_wr`=0), and never in an address phase.
- R6: With `phase_vld`=0, `ad_drive` is 0.
- R7: A high-to-low transition of `serr_n` with `nmi_en`=1 sets `nmi_req` exactly SERR_SYNC+1 rising clock edges after the new level is presented.
- R8: A falling `serr_n` while `nmi_en`=0 is ignored: `nmi_req` stays 0.
- R9: `nmi_req` stays set until a clock with `nmi_clr`=1 clears it. When a new falling edge is detected in the same clock as a clear, the request stays set.
- R10: While `rst_n` is 0, `par_out`, `par_drive` and `nmi_req` are 0.
- R11: A `serr_n` held low raises the request only once; after a clear it stays 0 until a fresh high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_vld | input | 1 | A bus phase is in progress this clock |
| phase_addr | input | 1 | 1 = address phase, 0 = data phase |
| role_mst | input | 1 | 1 = this agent is master, 0 = target |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| ad_val | input | 32 | Value on the AD lines this clock |
| cbe_val | input | 4 | Value on the C/BE lines this clock |
| serr_n | input | 1 | Shared system-error line, active low, asynchronous |
| nmi_en | input | 1 | Allows system errors to raise the interrupt request |
| nmi_clr | input | 1 | Clears the interrupt request |
| ad_drive | output | 1 | This agent owns the AD lines in the current phase |
| par_out | output | 1 | Even parity of the previous clock's AD and C/BE values |
| par_drive | output | 1 | Output enable for the parity pad |
| nmi_req | output | 1 | Sticky non-maskable interrupt request |

## Verification
The assertions assume that every phase and data input is at a known level at each rising edge once reset is released. They also assume that `serr_n` rests high at reset, so the first detected transition is a real one. The bench drives all inputs only at falling edges and holds them at defined values from time zero. Random bus phases, roles, directions and data run with `serr_n` parked high. The system-error line is then moved only in directed sequences that space its transitions further apart than the synchroniser latency.

// File: rtl/pcipar_pkg.sv
// Package: shared types and the ownership rule for the parity generator.
// Assumes a multiplexed bus where address and data share the AD lines.
package pcipar_pkg;

    // Description of the bus phase presented in one clock.
    typedef struct packed {
        logic vld;   // phase in progress
        logic addr;  // 1 = address phase, 0 = data phase
        logic mst;   // 1 = this agent initiated the cycle
        logic wr;    // 1 = write cycle
    } phase_t;

    // Which owner class a phase falls into.
    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_ADDR = 2'd1,
        OWN_DATA = 2'd2
    } own_kind_e;

    // Classify a phase by whether this agent places values on AD.
    function automatic own_kind_e own_kind(input phase_t ph);
        own_kind_e k;
        k = OWN_NONE;
        if (ph.vld) begin
            if (ph.addr) begin
                if (ph.mst) k = OWN_ADDR;
            end else if (ph.mst == ph.wr) begin
                // master writes or target reads supply the data
                k = OWN_DATA;
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/pcipar_tree.sv
// Module: pcipar_tree
// Even parity over the AD and C/BE values, folded lane by lane.
// Assumes AD_W is a multiple of CBE_W; each C/BE bit joins its lane.
module pcipar_tree #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic [AD_W-1:0]  ad_i,
    input  logic [CBE_W-1:0] cbe_i,
    output logic             par_o
);
    localparam int LANE_W = AD_W / CBE_W;

    logic [CBE_W-1:0] lane_par;

    // One XOR reduction per byte lane, each including its C/BE bit.
    for (genvar g = 0; g < CBE_W; g++) begin : g_lane
        always_comb lane_par[g] = (^ad_i[g*LANE_W +: LANE_W]) ^ cbe_i[g];
    end

    // Fold the lane results into the final even-parity bit.
    always_comb par_o = ^lane_par;

endmodule

// File: rtl/pcipar_own.sv
// Module: pcipar_own
// Decides whether this agent owns the AD lines in the current phase.
// Assumes the phase fields are valid in the same clock as the AD values.
module pcipar_own
    import pcipar_pkg::*;
(
    input  phase_t ph_i,
    output logic   drive_o
);
    own_kind_e kind;

    // Classify the phase and drive when any owned kind results.
    always_comb begin
        kind    = own_kind(ph_i);
        drive_o = (kind != OWN_NONE);
    end

endmodule

// File: rtl/pcipar_outreg.sv
// Module: pcipar_outreg
// Registers parity and its pad enable so both appear one clock after the
// phase. Assumes the synchronous active-low reset.
module pcipar_outreg (
    input  logic clk,
    input  logic rst_n,
    input  logic par_i,
    input  logic drive_i,
    output logic par_o,
    output logic drive_o
);
    // Capture this clock's parity and ownership for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_o   <= 1'b0;
            drive_o <= 1'b0;
        end else begin
            par_o   <= par_i;
            drive_o <= drive_i;
        end
    end

endmodule

// File: rtl/pcipar_serr.sv
// Module: pcipar_serr
// Synchronises the shared system-error line, detects a high-to-low
// transition and holds a sticky interrupt request. Assumes the line is
// asynchronous and rests high; SYNC >= 1 stages.
module pcipar_serr #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic serr_n_i,
    input  logic en_i,
    input  logic clr_i,
    output logic req_o
);
    logic [SYNC-1:0] sync_q;
    logic            last_q;
    logic            fall;

    if (SYNC == 1) begin : g_one
        // Single sampling stage.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 1'b1;
            else        sync_q <= serr_n_i;
        end
    end else begin : g_chain
        // Shift chain of sampling stages.
        always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '1;
            else        sync_q <= {sync_q[SYNC-2:0], serr_n_i};
        end
    end

    // Keep the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b1;
        else        last_q <= sync_q[SYNC-1];
    end

    // A high-to-low step of the synchronised level.
    always_comb fall = last_q & ~sync_q[SYNC-1];

    // Sticky request: a new enabled event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)            req_o <= 1'b0;
        else if (fall && en_i) req_o <= 1'b1;
        else if (clr_i)        req_o <= 1'b0;
    end

endmodule

// File: rtl/pcipar_top.sv
// Module: pcipar_top
// Parity generator for a master/target bus bridge plus system-error
// interrupt request. Assumes inputs are synchronous to clk except serr_n.
module pcipar_top
    import pcipar_pkg::*;
#(
    parameter int AD_W      = 32,
    parameter int CBE_W     = 4,
    parameter int SERR_SYNC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             phase_vld,
    input  logic             phase_addr,
    input  logic             role_mst,
    input  logic             cyc_wr,
    input  logic [AD_W-1:0]  ad_val,
    input  logic [CBE_W-1:0] cbe_val,
    input  logic             serr_n,
    input  logic             nmi_en,
    input  logic             nmi_clr,
    output logic             ad_drive,
    output logic             par_out,
    output logic             par_drive,
    output logic             nmi_req
);
    phase_t ph;
    logic   par_now;

    // Gather the phase fields into one record.
    always_comb ph = '{vld: phase_vld, addr: phase_addr, mst: role_mst, wr: cyc_wr};

    pcipar_tree #(.AD_W(AD_W), .CBE_W(CBE_W)) tree_i (
        .ad_i  (ad_val),
        .cbe_i (cbe_val),
        .par_o (par_now)
    );

    pcipar_own own_i (
        .ph_i    (ph),
        .drive_o (ad_drive)
    );

    pcipar_outreg out_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .par_i   (par_now),
        .drive_i (ad_drive),
        .par_o   (par_out),
        .drive_o (par_drive)
    );

    pcipar_serr #(.SYNC(SERR_SYNC)) serr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .serr_n_i (serr_n),
        .en_i     (nmi_en),
        .clr_i    (nmi_clr),
        .req_o    (nmi_req)
    );

endmodule

// File: rtl/pcipar_chk.sv
// Module: pcipar_chk
// Property checker for pcipar_top, attached by bind below.
module pcipar_chk #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             phase_vld,
    input logic             phase_addr,
    input logic             role_mst,
    input logic             cyc_wr,
    input logic [AD_W-1:0]  ad_val,
    input logic [CBE_W-1:0] cbe_val,
    input logic             nmi_en,
    input logic             nmi_clr,
    input logic             ad_drive,
    input logic             par_out,
    input logic             par_drive,
    input logic             nmi_req
);
    logic live;

    // Marks clocks that follow at least one clock out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (par_out == ^{$past(ad_val), $past(cbe_val)}));          // R1

    AST_PAR_OE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (par_drive == $past(ad_drive)));                         // R3

    AST_MST_ADDR_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && phase_addr && role_mst) |-> ad_drive);              // R4

    AST_TGT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_vld && phase_addr && !role_mst) |-> !ad_drive);            // R5

    AST_IDLE_NO_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_vld |-> !ad_drive);                                        // R6

    AST_NMI_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(nmi_req)) |-> $past(nmi_en));                      // R8

    AST_NMI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !nmi_clr) |=> nmi_req);                               // R9

endmodule

bind pcipar_top pcipar_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase_vld  (phase_vld),
    .phase_addr (phase_addr),
    .role_mst   (role_mst),
    .cyc_wr     (cyc_wr),
    .ad_val     (ad_val),
    .cbe_val    (cbe_val),
    .nmi_en     (nmi_en),
    .nmi_clr    (nmi_clr),
    .ad_drive   (ad_drive),
    .par_out    (par_out),
    .par_drive  (par_drive),
    .nmi_req    (nmi_req)
);

// File: tb/pcipar_top_tb_top.sv
module pcipar_top_tb_top;
    localparam int SYNC = 2;
    localparam int LAT  = SYNC + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_vld = 1'b0, phase_addr = 1'b0, role_mst = 1'b0, cyc_wr = 1'b0;
    logic [31:0] ad_val = '0;
    logic [3:0]  cbe_val = '0;
    logic        serr_n = 1'b1, nmi_en = 1'b0, nmi_clr = 1'b0;
    logic        ad_drive, par_out, par_drive, nmi_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pcipar_top #(.SERR_SYNC(SYNC)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_vld(phase_vld), .phase_addr(phase_addr),
        .role_mst(role_mst), .cyc_wr(cyc_wr), .ad_val(ad_val), .cbe_val(cbe_val),
        .serr_n(serr_n), .nmi_en(nmi_en), .nmi_clr(nmi_clr), .ad_drive(ad_drive),
        .par_out(par_out), .par_drive(par_drive), .nmi_req(nmi_req)
    );

    function automatic bit exp_own(bit v, bit a, bit m, bit w);
        if (!v) return 1'b0;
        if (a)  return m;
        return m ? w : !w;
    endfunction

    function automatic bit exp_par(logic [31:0] d, logic [3:0] c);
        bit p = 1'b0;
        for (int i = 0; i < 32; i++) p ^= d[i];
        for (int i = 0; i < 4; i++)  p ^= c[i];
        return p;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic phase_step(bit v, bit a, bit m, bit w, logic [31:0] d, logic [3:0] c,
                              inout bit pv, inout bit pp, inout bit pd, input string rq);
        @(negedge clk);
        if (pv) begin
            chk({rq, " R1 par"}, par_out, pp);
            chk("R3 par_drive", par_drive, pd);
        end
        phase_vld = v; phase_addr = a; role_mst = m; cyc_wr = w; ad_val = d; cbe_val = c;
        #1;
        chk(m ? "R4 ad_drive" : (v ? "R5 ad_drive" : "R6 ad_drive"), ad_drive, exp_own(v, a, m, w));
        pv = 1'b1; pp = exp_par(d, c); pd = exp_own(v, a, m, w);
    endtask

    initial begin
        bit pv = 1'b0, pp = 1'b0, pd = 1'b0;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 par_out", par_out, 1'b0);
        chk("R10 par_drive", par_drive, 1'b0);
        chk("R10 nmi_req", nmi_req, 1'b0);
        rst_n = 1'b1;

        // Directed phases: every ownership combination, R2 corner with all C/BE ones
        for (int k = 0; k < 16; k++)
            phase_step(k[3], k[2], k[1], k[0], 32'h0000_0001 << k, 4'hF, pv, pp, pd, "R2");
        phase_step(1, 0, 1, 1, 32'hFFFF_FFFF, 4'hF, pv, pp, pd, "R2");
        phase_step(1, 0, 0, 0, 32'h0000_0000, 4'hF, pv, pp, pd, "R2");
        phase_step(0, 0, 0, 0, 32'h8000_0000, 4'h0, pv, pp, pd, "R1");
        // Ownership ends: par_drive lingers one clock (R3)
        phase_step(1, 1, 1, 0, 32'h1234_5678, 4'h6, pv, pp, pd, "R3");
        phase_step(0, 0, 0, 0, 32'h0, 4'h0, pv, pp, pd, "R3");
        phase_step(0, 0, 0, 0, 32'h0, 4'h0, pv, pp, pd, "R3");

        // Random phases
        for (int n = 0; n < 3000; n++) begin
            bit [3:0] f = 4'($urandom);
            phase_step(f[3] | f[2], f[2], f[1], f[0], $urandom, 4'($urandom), pv, pp, pd, "R1");
        end
        phase_step(0, 0, 0, 0, 32'h0, 4'h0, pv, pp, pd, "R1");

        // R7: enabled falling edge, exact latency
        @(negedge clk); nmi_en = 1'b1; serr_n = 1'b0;
        repeat (LAT - 1) @(posedge clk);
        @(negedge clk); chk("R7 early", nmi_req, 1'b0);
        @(posedge clk);
        @(negedge clk); chk("R7 set", nmi_req, 1'b1);

        // R9: held while no clear
        repeat (4) @(negedge clk);
        chk("R9 hold", nmi_req, 1'b1);
        nmi_clr = 1'b1;
        @(negedge clk); nmi_clr = 1'b0;
        chk("R9 clear", nmi_req, 1'b0);

        // R11: still low, no re-raise
        repeat (6) @(negedge clk);
        chk("R11 no repeat", nmi_req, 1'b0);

        // R8: disabled edge ignored
        serr_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        nmi_en = 1'b0; serr_n = 1'b0;
        repeat (LAT + 3) @(negedge clk);
        chk("R8 ignored", nmi_req, 1'b0);
        nmi_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 no late raise", nmi_req, 1'b0);

        // R9: new edge in the same clock as clear keeps request
        serr_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        serr_n = 1'b0;
        repeat (LAT) @(negedge clk);
        chk("R7 set again", nmi_req, 1'b1);
        serr_n = 1'b1;
        repeat (LAT + 2) @(negedge clk);
        serr_n = 1'b0;
        repeat (SYNC) @(posedge clk);
        @(negedge clk); nmi_clr = 1'b1;
        @(negedge clk); nmi_clr = 1'b0;
        chk("R9 set wins", nmi_req, 1'b1);
        nmi_clr = 1'b1;
        @(negedge clk); nmi_clr = 1'b0;
        chk("R9 clear after", nmi_req, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule